// File: doc/BRIEF.md
# CSR Read-Modify-Write Execution Unit

This unit carries out the six control-and-status-register access operations of a hart against a small local register file. Each operation is presented for one cycle together with its 12-bit register address, the source operand (a register index plus value, or a 5-bit immediate held in the index field) and the destination index. In that same cycle the unit returns the old register value for writeback and raises an illegal-instruction flag. At the next clock edge it commits the new register value.

The unit works out from the operand indices, not from the operand values, whether a read and a write actually happen. Side effects then follow only those accesses that really occur. A swap whose destination is x0 performs no read. A set or clear whose source is x0, or whose immediate is zero, performs no write. In that case it cannot trap on a read-only register either.

The file holds four registers: a scratch register, a control register in which only some bits are writable, a retired-instruction counter and a read-only identity register. The counter counts up on a separate retire strobe. A CSR write to the counter in the same cycle replaces that increment.

The unit is purely a single-cycle datapath with no sequencing. There is no state machine, so no states or transitions are defined. The only storage is the three writable registers.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset the scratch, control and counter registers read as zero. While `op_valid` is low, `illegal`, `rd_we`, `csr_rd_fire` and `csr_wr_fire` stay low.
- R2: Operation codes are 001 swap, 010 set and 011 clear, plus 101, 110 and 111 for their immediate forms. A swap returns the old register value on `rd_val` with `rd_we` high, and the register takes the operand at the next edge.
- R3: A swap (register or immediate form) with `rd_idx` = 0 performs no read: `csr_rd_fire`, `rd_we` and `rd_val` are all zero. The write still takes place.
- R4: In the register forms a `rs1_idx` of 0 supplies an operand of zero whatever `rs1_val` holds, so a swap from x0 writes zero.
- R5: Set ORs the operand into the register and clear ANDs the register with the inverted operand. In the control register (address 0x300) only bits 7:0 are writable. The other bits keep their value.
- R6: A set or clear whose `rs1_idx` is 0 (register form) or whose immediate is 0 performs no write: `csr_wr_fire` is low and the register keeps its value. It still reads, with `csr_rd_fire` high, and raises no illegal flag even on a read-only register.
- R7: A set or clear whose `rs1_idx` is nonzero but whose value is zero still performs a write (`csr_wr_fire` high) of the unchanged value.
- R8: The immediate forms take `rs1_idx` as an unsigned 5-bit value, zero-extended to XLEN, and ignore `rs1_val`.
- R9: An address whose bits 11:10 are 2'b11 is read-only; the identity register sits at 0xF11. A write attempt to it raises `illegal`, suppresses `rd_we` and leaves it unchanged.
- R10: Codes 000 and 100, and any address other than 0x340, 0x300, 0xB02 or 0xF11, raise `illegal` with no read and no write.
- R11: The counter (address 0xB02) increments by one at each edge where `retire` is high. A read returns the value from before that cycle's increment.
- R12: A CSR write to the counter replaces a simultaneous increment, so the next read returns exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_code | input | 3 | Operation code |
| csr_addr | input | 12 | Register address |
| rs1_idx | input | 5 | Source register index or 5-bit immediate |
| rs1_val | input | XLEN | Source register value |
| rd_idx | input | 5 | Destination register index |
| retire | input | 1 | Retired-instruction strobe for the counter |
| rd_val | output | XLEN | Old register value for writeback |
| rd_we | output | 1 | Writeback enable |
| illegal | output | 1 | Illegal-instruction flag |
| csr_rd_fire | output | 1 | A register read actually happened |
| csr_wr_fire | output | 1 | A register write actually happened |

## Verification
The bench checks that read and write suppression is decided by index and not by value. A design that tested the operand value would skip the write for a nonzero source index holding zero. A design that tested the index for immediates would write on a zero immediate. Read-only protection is exercised both with a zero-mask set, which must not trap, and with a zero-valued nonzero register, which must trap; mixing up write intent and write effect fails one of the two. The counter is checked for a pre-increment read and for a same-cycle write that must win over retire. A design that added the increment after the write would read back one too many.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    typedef enum logic [2:0] {
        OP_RSV0  = 3'b000,
        OP_SWAP  = 3'b001,
        OP_SET   = 3'b010,
        OP_CLR   = 3'b011,
        OP_RSV4  = 3'b100,
        OP_SWAPI = 3'b101,
        OP_SETI  = 3'b110,
        OP_CLRI  = 3'b111
    } csr_op_e;

    typedef enum logic [1:0] {
        KIND_SWAP,
        KIND_SET,
        KIND_CLR,
        KIND_NONE
    } csr_kind_e;

    typedef struct packed {
        logic      rd_en;
        logic      wr_en;
        logic      bad_op;
        logic      imm;
        csr_kind_e kind;
    } csr_ctl_t;

    function automatic logic addr_is_ro(input logic [11:0] a);
        return a[11:10] == 2'b11;
    endfunction

endpackage

// File: rtl/csr_access_ctl.sv
module csr_access_ctl
    import csr_rmw_pkg::*;
(
    input  logic [2:0] op_code,
    input  logic [4:0] rs1_idx,
    input  logic [4:0] rd_idx,
    output csr_ctl_t   ctl
);

    always_comb begin
        ctl = '{rd_en: 1'b0, wr_en: 1'b0, bad_op: 1'b1, imm: 1'b0, kind: KIND_NONE};
        unique case (csr_op_e'(op_code))
            OP_SWAP, OP_SWAPI: begin
                ctl.kind   = KIND_SWAP;
                ctl.bad_op = 1'b0;
                ctl.rd_en  = (rd_idx != 5'd0);
                ctl.wr_en  = 1'b1;
                ctl.imm    = op_code[2];
            end
            OP_SET, OP_SETI, OP_CLR, OP_CLRI: begin
                ctl.kind   = op_code[0] ? KIND_CLR : KIND_SET;
                ctl.bad_op = 1'b0;
                ctl.rd_en  = 1'b1;
                ctl.wr_en  = (rs1_idx != 5'd0);
                ctl.imm    = op_code[2];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/csr_wdata_alu.sv
module csr_wdata_alu
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_kind_e       kind,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    input  logic [XLEN-1:0] wmask,
    output logic [XLEN-1:0] new_val
);

    logic [XLEN-1:0] cand;

    always_comb begin
        unique case (kind)
            KIND_SWAP: cand = operand;
            KIND_SET:  cand = old_val | operand;
            KIND_CLR:  cand = old_val & ~operand;
            default:   cand = old_val;
        endcase
        new_val = (old_val & ~wmask) | (cand & wmask);
    end

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile #(
    parameter int              XLEN        = 32,
    parameter logic [11:0]     SCRATCH_ADDR = 12'h340,
    parameter logic [11:0]     CTRL_ADDR    = 12'h300,
    parameter logic [11:0]     COUNT_ADDR   = 12'hB02,
    parameter logic [11:0]     ID_ADDR      = 12'hF11,
    parameter logic [XLEN-1:0] CTRL_WMASK   = 'hFF,
    parameter logic [XLEN-1:0] ID_VALUE     = 'h5A5A0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     addr,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_val,
    input  logic            retire,
    output logic            hit,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] wmask,
    output logic [XLEN-1:0] cnt_now
);

    logic [XLEN-1:0] scratch_q, ctrl_q, cnt_q;

    always_comb begin
        hit   = 1'b1;
        rdata = '0;
        wmask = '0;
        unique case (addr)
            SCRATCH_ADDR: begin rdata = scratch_q; wmask = '1;         end
            CTRL_ADDR:    begin rdata = ctrl_q;    wmask = CTRL_WMASK; end
            COUNT_ADDR:   begin rdata = cnt_q;     wmask = '1;         end
            ID_ADDR:      begin rdata = ID_VALUE;  wmask = '0;         end
            default:      hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scratch_q <= '0;
            ctrl_q    <= '0;
            cnt_q     <= '0;
        end else begin
            if (wr_en && addr == SCRATCH_ADDR) scratch_q <= wr_val;
            if (wr_en && addr == CTRL_ADDR)    ctrl_q    <= wr_val & CTRL_WMASK;
            if (wr_en && addr == COUNT_ADDR)   cnt_q     <= wr_val;
            else if (retire)                   cnt_q     <= cnt_q + 1'b1;
        end
    end

    assign cnt_now = cnt_q;

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter logic [11:0]     SCRATCH_ADDR = 12'h340,
    parameter logic [11:0]     CTRL_ADDR    = 12'h300,
    parameter logic [11:0]     COUNT_ADDR   = 12'hB02,
    parameter logic [11:0]     ID_ADDR      = 12'hF11,
    parameter logic [XLEN-1:0] CTRL_WMASK   = 'hFF,
    parameter logic [XLEN-1:0] ID_VALUE     = 'h5A5A0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [11:0]     csr_addr,
    input  logic [4:0]      rs1_idx,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [4:0]      rd_idx,
    input  logic            retire,
    output logic [XLEN-1:0] rd_val,
    output logic            rd_we,
    output logic            illegal,
    output logic            csr_rd_fire,
    output logic            csr_wr_fire
);

    csr_ctl_t        ctl;
    logic            hit;
    logic [XLEN-1:0] old_val, wmask, operand, wr_merged, cnt_now;

    csr_access_ctl u_ctl (
        .op_code (op_code),
        .rs1_idx (rs1_idx),
        .rd_idx  (rd_idx),
        .ctl     (ctl)
    );

    always_comb begin
        if (ctl.imm)              operand = XLEN'(rs1_idx);
        else if (rs1_idx == 5'd0) operand = '0;
        else                      operand = rs1_val;
    end

    csr_wdata_alu #(.XLEN(XLEN)) u_alu (
        .kind    (ctl.kind),
        .old_val (old_val),
        .operand (operand),
        .wmask   (wmask),
        .new_val (wr_merged)
    );

    always_comb begin
        illegal     = op_valid & (ctl.bad_op | ~hit | (ctl.wr_en & addr_is_ro(csr_addr)));
        csr_wr_fire = op_valid & ~illegal & ctl.wr_en;
        csr_rd_fire = op_valid & ~illegal & ctl.rd_en;
        rd_we       = csr_rd_fire & (rd_idx != 5'd0);
        rd_val      = csr_rd_fire ? old_val : '0;
    end

    csr_regfile #(
        .XLEN(XLEN), .SCRATCH_ADDR(SCRATCH_ADDR), .CTRL_ADDR(CTRL_ADDR),
        .COUNT_ADDR(COUNT_ADDR), .ID_ADDR(ID_ADDR),
        .CTRL_WMASK(CTRL_WMASK), .ID_VALUE(ID_VALUE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (csr_addr),
        .wr_en   (csr_wr_fire),
        .wr_val  (wr_merged),
        .retire  (retire),
        .hit     (hit),
        .rdata   (old_val),
        .wmask   (wmask),
        .cnt_now (cnt_now)
    );

endmodule

// File: rtl/csr_rmw_sva.sv
module csr_rmw_sva #(
    parameter int          XLEN       = 32,
    parameter logic [11:0] COUNT_ADDR = 12'hB02
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [2:0]      op_code,
    input logic [11:0]     csr_addr,
    input logic [4:0]      rs1_idx,
    input logic [4:0]      rd_idx,
    input logic            retire,
    input logic            rd_we,
    input logic            illegal,
    input logic            csr_rd_fire,
    input logic            csr_wr_fire,
    input logic [XLEN-1:0] wr_merged,
    input logic [XLEN-1:0] cnt_now
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !illegal && !rd_we && !csr_rd_fire && !csr_wr_fire); // R1

    AST_SWAP_X0_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[1:0] == 2'b01 && rd_idx == 5'd0 |-> !csr_rd_fire && !rd_we); // R3

    AST_SETCLR_X0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[1] && rs1_idx == 5'd0 |-> !csr_wr_fire && !illegal == csr_rd_fire); // R6

    AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && csr_addr[11:10] == 2'b11 |-> !csr_wr_fire); // R9

    AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !rd_we && !csr_rd_fire && !csr_wr_fire); // R10

    AST_CNT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        retire && !(csr_wr_fire && csr_addr == COUNT_ADDR) |=> cnt_now == $past(cnt_now) + 1'b1); // R11

    AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_fire && csr_addr == COUNT_ADDR |=> cnt_now == $past(wr_merged)); // R12

endmodule

bind csr_rmw_unit csr_rmw_sva #(.XLEN(XLEN), .COUNT_ADDR(COUNT_ADDR)) u_sva (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .csr_addr(csr_addr), .rs1_idx(rs1_idx), .rd_idx(rd_idx), .retire(retire),
    .rd_we(rd_we), .illegal(illegal), .csr_rd_fire(csr_rd_fire),
    .csr_wr_fire(csr_wr_fire), .wr_merged(wr_merged), .cnt_now(cnt_now)
);

// File: tb/csr_rmw_unit_tb.sv
module csr_rmw_unit_tb;

    localparam logic [11:0] A_SCR = 12'h340, A_CTL = 12'h300, A_CNT = 12'hB02, A_ID = 12'hF11;
    localparam logic [31:0] ID_V  = 32'h5A5A0001;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        op_valid = 1'b0, retire = 1'b0;
    logic [2:0]  op_code = '0;
    logic [11:0] csr_addr = '0;
    logic [4:0]  rs1_idx = '0, rd_idx = '0;
    logic [31:0] rs1_val = '0, rd_val;
    logic        rd_we, illegal, csr_rd_fire, csr_wr_fire;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    csr_rmw_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .csr_addr(csr_addr), .rs1_idx(rs1_idx), .rs1_val(rs1_val), .rd_idx(rd_idx),
        .retire(retire), .rd_val(rd_val), .rd_we(rd_we), .illegal(illegal),
        .csr_rd_fire(csr_rd_fire), .csr_wr_fire(csr_wr_fire)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Issue one operation, check the same-cycle outputs, let the edge commit it.
    task automatic op(input string tag, input logic [2:0] c, input logic [11:0] a,
                      input logic [4:0] s, input logic [31:0] sv, input logic [4:0] d,
                      input logic ret, input logic e_ill, input logic e_rdf,
                      input logic [31:0] e_val, input logic e_wr);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; csr_addr = a; rs1_idx = s; rs1_val = sv;
        rd_idx = d; retire = ret;
        #5;
        chk({tag, " illegal"}, 32'(illegal), 32'(e_ill));
        chk({tag, " read"}, 32'(csr_rd_fire), 32'(e_rdf));
        chk({tag, " rd_we"}, 32'(rd_we), 32'(e_rdf && d != 0));
        chk({tag, " write"}, 32'(csr_wr_fire), 32'(e_wr));
        if (e_rdf) chk({tag, " rd_val"}, rd_val, e_val);
        @(posedge clk); #1;
        op_valid = 1'b0; retire = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] e);
        op(tag, 3'b010, a, 5'd0, 32'hFFFF_FFFF, 5'd5, 1'b0, 1'b0, 1'b1, e, 1'b0);
    endtask

    task automatic t_reset;
        #5;
        chk("R1 idle illegal", 32'(illegal), 0);
        chk("R1 idle rd_we", 32'(rd_we), 0);
        rd("R1 scratch", A_SCR, 0);
        rd("R1 ctrl", A_CTL, 0);
        rd("R1 counter", A_CNT, 0);
    endtask

    task automatic t_swap;
        op("R2 swap1", 3'b001, A_SCR, 5'd3, 32'h1234_5678, 5'd1, 0, 0, 1, 32'h0, 1);
        op("R2 swap2", 3'b001, A_SCR, 5'd3, 32'hDEAD_BEEF, 5'd1, 0, 0, 1, 32'h1234_5678, 1);
        op("R3 swap rd=x0", 3'b001, A_SCR, 5'd4, 32'hCAFE_0001, 5'd0, 0, 0, 0, 32'h0, 1);
        rd("R3 readback", A_SCR, 32'hCAFE_0001);
        op("R3 swapi rd=x0", 3'b101, A_SCR, 5'd9, 32'h0, 5'd0, 0, 0, 0, 32'h0, 1);
        rd("R3 imm readback", A_SCR, 32'h9);
        op("R4 swap x0", 3'b001, A_SCR, 5'd0, 32'hFFFF_FFFF, 5'd2, 0, 0, 1, 32'h9, 1);
        rd("R4 zero written", A_SCR, 32'h0);
    endtask

    task automatic t_setclr;
        op("R5 ctrl swap", 3'b001, A_CTL, 5'd1, 32'hFFFF_FFFF, 5'd0, 0, 0, 0, 0, 1);
        rd("R5 ctrl mask", A_CTL, 32'h0000_00FF);
        op("R5 ctrl clr", 3'b011, A_CTL, 5'd1, 32'hFFFF_0F0F, 5'd1, 0, 0, 1, 32'hFF, 1);
        rd("R5 ctrl after clr", A_CTL, 32'h0000_00F0);
        op("R5 scr set", 3'b010, A_SCR, 5'd1, 32'h8000_0003, 5'd1, 0, 0, 1, 32'h0, 1);
        op("R5 scr clr", 3'b011, A_SCR, 5'd1, 32'h0000_0001, 5'd1, 0, 0, 1, 32'h8000_0003, 1);
        rd("R5 scr result", A_SCR, 32'h8000_0002);
        op("R6 seti uimm0", 3'b110, A_SCR, 5'd0, 32'hFFFF_FFFF, 5'd1, 0, 0, 1, 32'h8000_0002, 0);
        op("R6 clr x0", 3'b011, A_SCR, 5'd0, 32'hFFFF_FFFF, 5'd1, 0, 0, 1, 32'h8000_0002, 0);
        rd("R6 scr unchanged", A_SCR, 32'h8000_0002);
        op("R6 ro set x0", 3'b010, A_ID, 5'd0, 32'hFFFF_FFFF, 5'd1, 0, 0, 1, ID_V, 0);
        op("R6 ro clri 0", 3'b111, A_ID, 5'd0, 32'h0, 5'd0, 0, 0, 1, ID_V, 0);
        op("R7 set zero val", 3'b010, A_SCR, 5'd7, 32'h0, 5'd1, 0, 0, 1, 32'h8000_0002, 1);
        rd("R7 unchanged", A_SCR, 32'h8000_0002);
    endtask

    task automatic t_imm;
        op("R8 swapi", 3'b101, A_SCR, 5'd31, 32'hFFFF_0000, 5'd1, 0, 0, 1, 32'h8000_0002, 1);
        rd("R8 zero-ext", A_SCR, 32'h0000_001F);
        op("R8 clri", 3'b111, A_SCR, 5'd5, 32'hFFFF_FFFF, 5'd1, 0, 0, 1, 32'h1F, 1);
        op("R8 seti", 3'b110, A_SCR, 5'd16, 32'h0, 5'd1, 0, 0, 1, 32'h1A, 1);
        rd("R8 result", A_SCR, 32'h0000_001A);
    endtask

    task automatic t_illegal;
        op("R9 ro swap", 3'b001, A_ID, 5'd1, 32'h0, 5'd1, 0, 1, 0, 0, 0);
        op("R9 ro set nz-idx zero", 3'b010, A_ID, 5'd6, 32'h0, 5'd1, 0, 1, 0, 0, 0);
        rd("R9 ro unchanged", A_ID, ID_V);
        op("R10 op000", 3'b000, A_SCR, 5'd1, 32'h1, 5'd1, 0, 1, 0, 0, 0);
        op("R10 op100", 3'b100, A_SCR, 5'd1, 32'h1, 5'd1, 0, 1, 0, 0, 0);
        op("R10 bad addr", 3'b010, 12'h123, 5'd0, 32'h0, 5'd1, 0, 1, 0, 0, 0);
        rd("R10 scr intact", A_SCR, 32'h0000_001A);
    endtask

    task automatic t_counter;
        op("R11 read pre", 3'b010, A_CNT, 5'd0, 32'h0, 5'd1, 1, 0, 1, 32'd0, 0);
        op("R11 read pre2", 3'b010, A_CNT, 5'd0, 32'h0, 5'd1, 1, 0, 1, 32'd1, 0);
        rd("R11 after two", A_CNT, 32'd2);
        op("R12 write+retire", 3'b001, A_CNT, 5'd2, 32'd100, 5'd1, 1, 0, 1, 32'd2, 1);
        op("R12 next read", 3'b010, A_CNT, 5'd0, 32'h0, 5'd1, 1, 0, 1, 32'd100, 0);
        rd("R12 then inc", A_CNT, 32'd101);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_swap();
        t_setclr();
        t_imm();
        t_illegal();
        t_counter();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule